// File: doc/BRIEF.md
# Polled Command Handshake Register Port

This block is the device side of a command hand-off that a processor runs entirely by polling. The host writes an opcode into a command register. It then writes a go bit into the status register. One cycle after go is seen, the device copies the opcode into a private latch, clears the go flag and raises busy. It then runs a placeholder operation that lasts a fixed number of clock cycles.

When the operation ends, busy falls and a done flag rises on the same clock edge. The block has no interrupt output. The host finds out that the work is finished only by reading the status register over and over. The done flag stays set until the host issues the next go.

Access is through a single-cycle register port. Writes take effect on the clock edge where the write strobe is high. Reads are combinational from the address. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `poll_cmd_port`

## Requirements
- R1: After reset, reads of the command register (address 0), the status register (address 1) and the latched-command register (address 2) all return zero.
- R2: A write to address 0 stores the low CMD_W bits of the write data, and address 0 reads them back. Writes to any other address leave it unchanged.
- R3: The status register reads as {done at bit 2, busy at bit 1, pending at bit 0}. A write to address 1 with bit 0 set, made while busy and pending are both clear, sets pending and clears done on that edge.
- R4: On the edge after pending is set, the device copies the command register into address 2, sets busy and clears pending.
- R5: Busy stays set for exactly OP_CYCLES clock cycles. On the edge where it clears, done is set.
- R6: A go write made while busy is ignored. Status and the latched command are unchanged by it, and no second operation follows.
- R7: Writes to the command register while busy do not change the latched command.
- R8: Done stays set until the next accepted go write. A write to address 1 with bit 0 clear has no effect.
- R9: Busy is never set together with pending or with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W | Register address for reads and writes |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for `addr` |

## Verification
The assertions assume that the host drives at most one write per cycle. They also assume that a go request is recognised only from bit 0 of a write to address 1, and that the address and data are stable around the sampling edge. The bench drives every input on the falling clock edge and holds it for a full cycle. It lowers the write strobe after each single-cycle write. It polls status only through the read port, so the assumed host behaviour is the only stimulus the design ever sees.

// File: rtl/pch_pkg.sv
package pch_pkg;
  localparam int ADDR_CMD  = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_LAT  = 2;
  localparam int STAT_GO   = 0;

  typedef struct packed {
    logic done;
    logic busy;
    logic pend;
  } stat_t;
endpackage

// File: rtl/pch_rst_sync.sv
module pch_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pch_cmd_reg.sv
module pch_cmd_reg #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmd,
  input  logic [CMD_W-1:0] wr_val,
  output logic [CMD_W-1:0] cmd_q
);
  logic [CMD_W-1:0] cmd_d;
  logic             cmd_en;

  always_comb begin
    cmd_en = wr_cmd;
    cmd_d  = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end
endmodule

// File: rtl/pch_timer.sv
module pch_timer #(
  parameter int OP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic last
);
  generate
    if (OP_CYCLES > 1) begin : g_count
      localparam int CNT_W = $clog2(OP_CYCLES);
      localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(OP_CYCLES - 1);
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             cnt_en;

      always_comb begin
        cnt_en = 1'b0;
        cnt_d  = cnt_q;
        if (load) begin
          cnt_en = 1'b1;
          cnt_d  = LOAD_VAL;
        end else if (run && (cnt_q != '0)) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign last = (cnt_q == '0);
    end else begin : g_single
      assign last = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/pch_seq.sv
module pch_seq #(
  parameter int CMD_W     = 8,
  parameter int OP_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CMD_W-1:0] cmd_in,
  output logic             pend,
  output logic             busy,
  output logic             done,
  output logic [CMD_W-1:0] lat_cmd
);
  logic             pend_d, busy_d, done_d;
  logic [CMD_W-1:0] lat_d;
  logic             lat_en;
  logic             op_last;

  pch_timer #(.OP_CYCLES(OP_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (pend),
    .run   (busy),
    .last  (op_last)
  );

  always_comb begin
    pend_d = pend;
    busy_d = busy;
    done_d = done;
    lat_d  = lat_cmd;
    lat_en = 1'b0;
    if (pend) begin
      pend_d = 1'b0;
      busy_d = 1'b1;
      lat_d  = cmd_in;
      lat_en = 1'b1;
    end else if (busy) begin
      if (op_last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else if (go) begin
      pend_d = 1'b1;
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      pend <= pend_d;
      busy <= busy_d;
      done <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_cmd <= '0;
    else if (lat_en) lat_cmd <= lat_d;
  end
endmodule

// File: rtl/poll_cmd_port.sv
module poll_cmd_port #(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8,
  parameter int CMD_W     = 8,
  parameter int OP_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import pch_pkg::*;

  logic             rst_sync_n;
  logic             wr_cmd, go;
  logic [CMD_W-1:0] cmd_q, lat_cmd;
  logic             pend, busy, done;
  stat_t            stat;

  pch_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    wr_cmd = wr_en && (addr == ADDR_W'(ADDR_CMD));
    go     = wr_en && (addr == ADDR_W'(ADDR_STAT)) && wdata[STAT_GO];
  end

  pch_cmd_reg #(.CMD_W(CMD_W)) u_cmd (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_cmd (wr_cmd),
    .wr_val (wdata[CMD_W-1:0]),
    .cmd_q  (cmd_q)
  );

  pch_seq #(.CMD_W(CMD_W), .OP_CYCLES(OP_CYCLES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .go      (go),
    .cmd_in  (cmd_q),
    .pend    (pend),
    .busy    (busy),
    .done    (done),
    .lat_cmd (lat_cmd)
  );

  always_comb begin
    stat.done = done;
    stat.busy = busy;
    stat.pend = pend;
    unique case (addr)
      ADDR_W'(ADDR_CMD):  rdata = DATA_W'(cmd_q);
      ADDR_W'(ADDR_STAT): rdata = DATA_W'(stat);
      ADDR_W'(ADDR_LAT):  rdata = DATA_W'(lat_cmd);
      default:            rdata = '0;
    endcase
  end
endmodule

// File: rtl/pch_chk.sv
module pch_chk #(
  parameter int ADDR_W    = 2,
  parameter int CMD_W     = 8,
  parameter int OP_CYCLES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wbit0,
  input logic              pend,
  input logic              busy,
  input logic              done,
  input logic [CMD_W-1:0]  lat_cmd,
  input logic [CMD_W-1:0]  cmd_reg
);
  import pch_pkg::*;

  logic go_req;
  int   run_len;

  assign go_req = wr_en && (addr == ADDR_W'(ADDR_STAT)) && wbit0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  // R9
  pend_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend && busy));
  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R3
  go_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_req && !busy && !pend) |=> (pend && !done));
  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> (busy && !pend));
  // R4
  start_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> (lat_cmd == $past(cmd_reg)));
  // R5
  op_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && run_len == OP_CYCLES));
  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(lat_cmd));
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go_req) |=> done);
  // R6
  busy_go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go_req) |=> !pend);
endmodule

bind poll_cmd_port pch_chk #(
  .ADDR_W    (ADDR_W),
  .CMD_W     (CMD_W),
  .OP_CYCLES (OP_CYCLES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wbit0   (wdata[0]),
  .pend    (pend),
  .busy    (busy),
  .done    (done),
  .lat_cmd (lat_cmd),
  .cmd_reg (cmd_q)
);

// File: tb/poll_cmd_port_test.sv
module poll_cmd_port_test;
  localparam int AW = 2;
  localparam int DW = 8;
  localparam int N  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  poll_cmd_port #(.ADDR_W(AW), .DATA_W(DW), .CMD_W(DW), .OP_CYCLES(N)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    rd(0, v); chk("R1 cmd after reset", v, 8'h00);
    rd(1, v); chk("R1 status after reset", v, 8'h00);
    rd(2, v); chk("R1 latch after reset", v, 8'h00);
  endtask

  task automatic t_cmd_rw;
    logic [DW-1:0] v;
    wr(0, 8'hA5);
    rd(0, v); chk("R2 cmd readback", v, 8'hA5);
    wr(2, 8'h11);
    rd(0, v); chk("R2 cmd kept after other write", v, 8'hA5);
    rd(2, v); chk("R2 latch not writable", v, 8'h00);
    wr(1, 8'hFE);
    rd(1, v); chk("R8 go bit clear no effect", v, 8'h00);
  endtask

  task automatic t_full_op;
    logic [DW-1:0] v;
    wr(0, 8'h3C);
    wr(1, 8'h01);
    rd(1, v); chk("R3 pending after go", v, 8'h01);
    step(1);
    rd(1, v); chk("R4 busy after pending", v, 8'h02);
    rd(2, v); chk("R4 command latched", v, 8'h3C);
    step(N - 1);
    rd(1, v); chk("R5 still busy at last cycle", v, 8'h02);
    step(1);
    rd(1, v); chk("R5 done as busy falls", v, 8'h04);
  endtask

  task automatic t_done_hold;
    logic [DW-1:0] v;
    step(5);
    rd(1, v); chk("R8 done held", v, 8'h04);
    wr(1, 8'h00);
    rd(1, v); chk("R8 zero write keeps done", v, 8'h04);
    wr(0, 8'h5A);
    wr(1, 8'h01);
    rd(1, v); chk("R3 go clears done", v, 8'h01);
  endtask

  task automatic t_busy_ignore;
    logic [DW-1:0] v;
    int waited;
    step(1);
    rd(1, v); chk("R4 busy on second op", v, 8'h02);
    rd(2, v); chk("R4 second command latched", v, 8'h5A);
    wr(0, 8'h77);
    wr(1, 8'h01);
    rd(1, v); chk("R6 go while busy ignored", v, 8'h02);
    rd(2, v); chk("R7 latch stable during busy", v, 8'h5A);
    waited = 0;
    rd(1, v);
    while (v != 8'h04 && waited < 4 * N) begin
      if (v[1] && (v[0] || v[2])) chk("R9 exclusive flags", v, 8'h02);
      step(1);
      waited++;
      rd(1, v);
    end
    chk("R5 second op completes", v, 8'h04);
    step(3);
    rd(1, v); chk("R6 no restart after ignored go", v, 8'h04);
    rd(2, v); chk("R7 latch after op", v, 8'h5A);
    rd(0, v); chk("R7 cmd reg took busy write", v, 8'h77);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
          fails++;
          checks++;
          $display("FAIL R5 watchdog actual=timeout expected=completion");
          $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
          $finish;
        end
      end
    join_none
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_cmd_rw();
    t_full_op();
    t_done_hold();
    t_busy_ignore();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule